// File: doc/BRIEF.md
# SPI Interrupt Status and Enable Unit

This unit gathers the single-cycle event pulses of an SPI controller into an eleven-bit sticky status register and gates them with an eleven-bit enable register. It drives one level-sensitive interrupt line. The line stays high while any pending status bit is also enabled.

Software reaches both registers through a small synchronous register port. A write to the status register clears every bit that is written as one, so writing back a value just read acknowledges exactly those events. A status bit records its event whether or not that event is enabled. Software can therefore poll masked events and enable them later without losing them.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status register, the enable register and `irq_o` are all zero.
- R2: A one on bit n of `evt_i` sets status bit n at that clock edge, whether or not bit n is enabled. The bit map is: 0 receive done, 1 transmit done, 2 receive overflow, 3 transmit underflow, 4 receive DMA done, 5 transmit DMA done, 6 receive FIFO full, 7 transmit FIFO empty, 8 receive threshold reached, 9 transmit threshold reached, 10 frame end.
- R3: A status bit that is set stays set until software clears it.
- R4: A write to register address 0 (status) clears each status bit whose data bit is one and leaves the other bits unchanged.
- R5: A write of all ones (for example 0x1FFF) to the status register clears every pending bit.
- R6: If an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R7: A write to register address 1 (enable) loads data bits 10..0 into the enable register. Reading address 1 returns the enable value.
- R8: `irq_o` is high in the cycle after (status AND enable) is non-zero, and low in the cycle after it is zero.
- R9: With the enable register at zero, `irq_o` stays low while any status bits are pending.
- R10: Data bits 31..11 read as zero from both registers, and writes to those bits have no effect.
- R11: Reading address 0 returns status. Addresses 2 and 3 read as zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 11 | Event pulses, one bit per event source |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Level interrupt request, registered |

## Verification
The assertions check the following on every cycle:
- an event always lands in status;
- cleared bits drop unless an event hits them in the same cycle;
- untouched status bits hold;
- `irq_o` follows the masked status with a one-cycle lag;
- the upper read bits stay zero.

Some properties only the bench's scenarios can show. These are the exact read-back value after every one of the 2048 clear masks, and the interrupt level under all 2048 enable patterns. The bench also shows that unused addresses really leave both registers alone, and that every event position maps to the bit named for it.

// File: rtl/spi_irq_pkg.sv
// Package: shared constants of the SPI interrupt unit.
// Assumes: one status bit and one enable bit per event source.
package spi_irq_pkg;
    localparam int unsigned EVT_N = 11;

    // Event positions (software decodes these).
    localparam int unsigned EV_RX_DONE   = 0;
    localparam int unsigned EV_TX_DONE   = 1;
    localparam int unsigned EV_RX_OVF    = 2;
    localparam int unsigned EV_TX_UNF    = 3;
    localparam int unsigned EV_RX_DMA    = 4;
    localparam int unsigned EV_TX_DMA    = 5;
    localparam int unsigned EV_RX_FULL   = 6;
    localparam int unsigned EV_TX_EMPTY  = 7;
    localparam int unsigned EV_RX_LEVEL  = 8;
    localparam int unsigned EV_TX_LEVEL  = 9;
    localparam int unsigned EV_FRAME_END = 10;

    typedef logic [EVT_N-1:0] evt_vec_t;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_RSV2   = 2'd2,
        SEL_RSV3   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/spi_irq_status_bank.sv
// Module: sticky status bits with write-one-to-clear.
// Each bit sets on its event pulse and drops on a clear pulse.
// An event wins over a clear in the same cycle.
// Assumes: clr_i is already qualified by the write strobe and address.
module spi_irq_status_bank #(
    parameter int unsigned N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    logic [N-1:0] stat_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        // Purpose: per-bit set/clear with event priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[b] <= 1'b0;
            else if (evt_i[b])
                stat_q[b] <= 1'b1;
            else if (clr_i[b])
                stat_q[b] <= 1'b0;
        end
    end

    assign status_o = stat_q;

    // R2: every event pulse appears in status at the next sample.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R6: an event and a clear on the same bit leave the bit set.
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & clr_i) != '0) |=> ((status_o & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));

    // R4: cleared bits with no event drop.
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((status_o & $past(clr_i & ~evt_i)) == '0));

    // R3: set bits without a clear hold.
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i)));
endmodule

// File: rtl/spi_irq_enable_reg.sv
// Module: enable mask register, one bit per event source.
// Assumes: we_i is already qualified by the address decode.
module spi_irq_enable_reg #(
    parameter int unsigned N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] enable_o
);
    logic [N-1:0] en_q;

    // Purpose: load the mask on a write, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (we_i)
            en_q <= wdata_i;
    end

    assign enable_o = en_q;

    // R7: the written mask is visible the cycle after the write.
    a_r7_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (enable_o == $past(wdata_i)));

    // R7: without a write the mask holds.
    a_r7_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(enable_o));
endmodule

// File: rtl/spi_irq_out.sv
// Module: masked OR reduction driving a registered interrupt line.
// Assumes: consumers treat irq_o as a level and tolerate one cycle of lag.
module spi_irq_out #(
    parameter int unsigned N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status_i,
    input  logic [N-1:0] enable_i,
    output logic         irq_o
);
    logic [N-1:0] live;
    logic         irq_q;

    // Purpose: pick the pending, enabled sources.
    always_comb begin
        live = status_i & enable_i;
    end

    // Purpose: register the OR so the output pin is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |live;
    end

    assign irq_o = irq_q;

    // R8: a pending enabled source raises irq at the next edge.
    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_i & enable_i) != '0) |=> irq_o);

    // R8: with no pending enabled source irq drops at the next edge.
    a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_i & enable_i) == '0) |=> !irq_o);

    // R9: an all-zero mask keeps irq low.
    a_r9_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i == '0) |=> !irq_o);
endmodule

// File: rtl/spi_irq_ctrl.sv
// Module: top of the SPI interrupt unit.
// It decodes the register port, muxes read data and joins the status bank,
// the enable register and the output stage.
// Assumes: DATA_W >= EVT_N and register reads have no side effects.
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_N-1:0]  evt_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int unsigned PAD_W = DATA_W - EVT_N;

    evt_vec_t status;
    evt_vec_t enable;
    evt_vec_t clr_vec;
    evt_vec_t rd_sel;
    logic     wr_status;
    logic     wr_enable;

    // Purpose: decode writes to the two live registers.
    always_comb begin
        wr_status = reg_wr_i && (reg_addr_i == ADDR_W'(SEL_STATUS));
        wr_enable = reg_wr_i && (reg_addr_i == ADDR_W'(SEL_ENABLE));
        clr_vec   = wr_status ? reg_wdata_i[EVT_N-1:0] : '0;
    end

    spi_irq_status_bank #(.N(EVT_N)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (clr_vec),
        .status_o (status)
    );

    spi_irq_enable_reg #(.N(EVT_N)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (wr_enable),
        .wdata_i  (reg_wdata_i[EVT_N-1:0]),
        .enable_o (enable)
    );

    spi_irq_out #(.N(EVT_N)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .enable_i (enable),
        .irq_o    (irq_o)
    );

    // Purpose: read mux; reserved addresses and upper bits return zero.
    always_comb begin
        if (reg_addr_i == ADDR_W'(SEL_STATUS))
            rd_sel = status;
        else if (reg_addr_i == ADDR_W'(SEL_ENABLE))
            rd_sel = enable;
        else
            rd_sel = '0;
        reg_rdata_o = {{PAD_W{1'b0}}, rd_sel};
    end

    // R10: upper read bits are always zero.
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[DATA_W-1:EVT_N] == '0));

    // R11: a write to a reserved address leaves the enable mask alone.
    a_r11_rsv_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i[ADDR_W-1:1] != '0) |=> $stable(enable));
endmodule

// File: tb/spi_irq_ctrl_tb.sv
module spi_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [31:0] ALL11 = 32'h7FF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] evt;
    logic [1:0]  addr;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [10:0] m);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        rst_n = 1'b0; evt = '0; addr = '0; wr = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_read(2'd0, v); chk("R1 status", v, 32'h0);
        reg_read(2'd1, v); chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 / R3 / R9: each event position sets its own bit, masked, and sticks
        for (int b = 0; b < 11; b++) begin
            pulse(11'(1 << b));
            @(negedge clk);
            reg_read(2'd0, v); chk("R2 event bit", v, 32'(1 << b));
            chk("R9 masked irq", {31'b0, irq}, 32'h0);
            repeat (3) @(negedge clk);
            reg_read(2'd0, v); chk("R3 sticky", v, 32'(1 << b));
            reg_write(2'd0, 32'(1 << b));
            reg_read(2'd0, v); chk("R4 single clear", v, 32'h0);
        end

        // R7 / R10: enable write and read-back with upper bits
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, v); chk("R7 R10 enable readback", v, ALL11);

        // R8: rise and fall of irq
        pulse(11'h004);
        chk("R8 irq lag", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq high", {31'b0, irq}, 32'h1);
        reg_write(2'd0, 32'h004);
        chk("R8 irq still high", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R8 irq low", {31'b0, irq}, 32'h0);

        // R6: event wins over a same-cycle clear
        pulse(11'h010);
        evt = 11'h008;
        reg_write(2'd0, 32'h018);
        evt = '0;
        reg_read(2'd0, v); chk("R6 event wins", v, 32'h008);
        reg_write(2'd0, 32'h1FFF);
        reg_read(2'd0, v); chk("R5 all clear", v, 32'h0);

        // R10 / R11: upper-bit and reserved-address writes have no effect
        pulse(11'h7FF);
        reg_write(2'd0, 32'hFFFF_F800);
        reg_read(2'd0, v); chk("R10 upper write ignored", v, ALL11);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_write(2'd3, 32'h0);
        reg_read(2'd0, v); chk("R11 status unchanged", v, ALL11);
        reg_read(2'd1, v); chk("R11 enable unchanged", v, ALL11);
        reg_read(2'd2, v); chk("R11 rsv2 zero", v, 32'h0);
        reg_read(2'd3, v); chk("R11 rsv3 zero", v, 32'h0);

        // R8 / R9: sweep all enable patterns with every status bit pending
        for (int e = 0; e < 2048; e++) begin
            reg_write(2'd1, 32'(e));
            @(negedge clk);
            chk(e == 0 ? "R9 sweep" : "R8 sweep", {31'b0, irq}, (e != 0) ? 32'h1 : 32'h0);
        end
        reg_write(2'd1, 32'h0);

        // R4 / R5: sweep all clear masks from a full status
        for (int m = 0; m < 2048; m++) begin
            pulse(11'h7FF);
            reg_write(2'd0, 32'(m));
            reg_read(2'd0, v);
            chk(m == 2047 ? "R5 sweep" : "R4 sweep", v, ALL11 & ~32'(m));
        end

        // R1: reset clears everything again
        reg_write(2'd1, 32'h7FF);
        pulse(11'h7FF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(2'd0, v); chk("R1 status after reset", v, 32'h0);
        reg_read(2'd1, v); chk("R1 enable after reset", v, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule